// File: doc/BRIEF.md
# Per-Chip-Select Wait State Generator

This block stretches memory cycles that hit the ROM chip select or the RAM chip select. An 8-bit control register holds an enable bit and a 3-bit count for each of the two selects. The CPU writes this register over a simple I/O write port. When a memory cycle begins, the block takes the decoded selects and the wait count requested by the CPU's built-in wait generator. It captures the larger of that count and its own count for the active select. It then holds a wait output high for exactly that many clock cycles.

Address decoding and the CPU bus sequencer sit outside the block. The block sees a one-cycle cycle-start strobe, the two select lines and the internal wait count, and it drives a single registered wait line back to the sequencer. When the count for the active select is disabled, only the internal count applies. When the cycle hits neither select, the internal count also applies on its own.

Top module: `cswg_top`

## Requirements
- R1: A write with `io_wr` high and `io_addr` equal to 0xD8 loads `io_wdata` into the control register, and `cfg_q` shows the new value from the next cycle. A write to any other address leaves `cfg_q` unchanged.
- R2: Control register layout: bit 3 is the ROM-select enable and bits 2:0 are the ROM-select count. Bit 7 is the RAM-select enable and bits 6:4 are the RAM-select count.
- R3: Synchronous active-high reset sets `cfg_q` to 0x77 (both enables clear, both counts all ones) and drives `wait_o` low.
- R4: When the active select is enabled, a count field value n gives that select n+1 wait states, so the values 0 to 7 give 1 to 8 waits.
- R5: When the enable bit of the active select is clear, that select contributes zero waits, and the cycle gets `cpu_waits` waits.
- R6: The number of waits inserted is the maximum of the select's contribution and `cpu_waits`.
- R7: A cycle with neither select asserted gets exactly `cpu_waits` waits, whatever the register holds.
- R8: When both selects are asserted, the ROM-select enable and count apply and the RAM fields are ignored.
- R9: `wait_o` goes high in the cycle after the cycle-start strobe and stays high for exactly N consecutive cycles, then goes low. N is the computed count. When N is 0, `wait_o` stays low.
- R10: The count is captured when the cycle starts. A register write during the waits does not change the current cycle, and a cycle-start strobe while `wait_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O address low byte |
| io_wdata | input | 8 | I/O write data |
| cfg_q | output | 8 | Current control register value |
| cyc_start | input | 1 | One-cycle memory cycle start strobe |
| rom_sel | input | 1 | Decoded ROM chip select for this cycle |
| ram_sel | input | 1 | Decoded RAM chip select for this cycle |
| cpu_waits | input | 3 | Wait count from the CPU's internal generator |
| wait_o | output | 1 | Registered wait request to the bus sequencer |

## Verification
The assertions check the following on every cycle: the register write and its address filter, the reset value, and that an enabled select always gives at least one wait. They also check that a cycle with no selects and no internal count never waits, and that the wait line holds while the counter has waits left and drops after the last one. The exact length of each wait window can only be shown by the bench's scenarios, compared against its own model. This covers every count from 1 to 8 on both selects, the maximum rule in both directions, ROM priority, a write made in the middle of a cycle, and a start strobe that arrives while the block is busy.

// File: rtl/cswg_pkg.sv
package cswg_pkg;
  typedef enum logic [0:0] {
    SEL_ROM = 1'b0,
    SEL_RAM = 1'b1
  } sel_e;

  localparam int NUM_SEL = 2;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cswg_cfg_reg.sv
module cswg_cfg_reg #(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'hD8,
  parameter logic [REG_W-1:0]  RESET_VAL = 8'h77
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  cfg_q
);
  logic hit;

  always_comb hit = io_wr && (io_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RESET_VAL;
    end else if (hit) begin
      cfg_q <= io_wdata;
    end
  end
endmodule

// File: rtl/cswg_select.sv
module cswg_select
  import cswg_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int CPU_W   = 3,
  parameter int CNT_W   = 4,
  localparam int LANE_W = FIELD_W + 1,
  localparam int REG_W  = NUM_SEL * LANE_W
) (
  input  logic [REG_W-1:0] cfg,
  input  logic             rom_sel,
  input  logic             ram_sel,
  input  logic [CPU_W-1:0] cpu_waits,
  output logic [CNT_W-1:0] need
);
  logic [CNT_W-1:0] lane_cnt [NUM_SEL];
  logic [NUM_SEL-1:0] lane_hit;
  logic [CNT_W-1:0] cs_cnt;
  logic [CNT_W-1:0] cpu_ext;

  always_comb begin
    lane_hit          = '0;
    lane_hit[SEL_ROM] = rom_sel;
    lane_hit[SEL_RAM] = ram_sel && !rom_sel;
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_lane
    logic             en;
    logic [FIELD_W-1:0] fld;
    always_comb begin
      en  = cfg[i*LANE_W + FIELD_W];
      fld = cfg[i*LANE_W +: FIELD_W];
      if (en && lane_hit[i]) begin
        lane_cnt[i] = CNT_W'(fld) + CNT_W'(1);
      end else begin
        lane_cnt[i] = '0;
      end
    end
  end

  always_comb begin
    cs_cnt = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      cs_cnt = cs_cnt | lane_cnt[k];
    end
    cpu_ext = CNT_W'(cpu_waits);
    need    = (cs_cnt > cpu_ext) ? cs_cnt : cpu_ext;
  end
endmodule

// File: rtl/cswg_counter.sv
module cswg_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             wait_o
);
  logic [CNT_W-1:0] nxt;
  logic             busy;

  always_comb begin
    busy = (remain != '0);
    if (busy) begin
      nxt = remain - CNT_W'(1);
    end else if (start) begin
      nxt = load_val;
    end else begin
      nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      wait_o <= 1'b0;
    end else begin
      remain <= nxt;
      wait_o <= (nxt != '0);
    end
  end
endmodule

// File: rtl/cswg_top.sv
module cswg_top
  import cswg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 3,
  parameter int CPU_W   = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hD8,
  localparam int LANE_W = FIELD_W + 1,
  localparam int REG_W  = NUM_SEL * LANE_W,
  localparam int CNT_W  = (LANE_W > CPU_W) ? LANE_W : CPU_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  cfg_q,
  input  logic              cyc_start,
  input  logic              rom_sel,
  input  logic              ram_sel,
  input  logic [CPU_W-1:0]  cpu_waits,
  output logic              wait_o
);
  localparam logic [LANE_W-1:0] LANE_RST = {1'b0, {FIELD_W{1'b1}}};
  localparam logic [REG_W-1:0]  CFG_RST  = {NUM_SEL{LANE_RST}};

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] remain;

  cswg_cfg_reg #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .REG_ADDR (REG_ADDR),
    .RESET_VAL(CFG_RST)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .cfg_q   (cfg_q)
  );

  cswg_select #(
    .FIELD_W(FIELD_W),
    .CPU_W  (CPU_W),
    .CNT_W  (CNT_W)
  ) u_sel (
    .cfg      (cfg_q),
    .rom_sel  (rom_sel),
    .ram_sel  (ram_sel),
    .cpu_waits(cpu_waits),
    .need     (need)
  );

  cswg_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .start   (cyc_start),
    .load_val(need),
    .remain  (remain),
    .wait_o  (wait_o)
  );
endmodule

// File: rtl/cswg_chk.sv
module cswg_chk #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 8,
  parameter int CPU_W  = 3,
  parameter int CNT_W  = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hD8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [REG_W-1:0]  io_wdata,
  input logic [REG_W-1:0]  cfg_q,
  input logic              cyc_start,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic [CPU_W-1:0]  cpu_waits,
  input logic              wait_o,
  input logic [CNT_W-1:0]  remain
);
  a_r1_write_hit: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == REG_ADDR) |=> (cfg_q == $past(io_wdata)));

  a_r1_write_miss: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == REG_ADDR) |=> $stable(cfg_q));

  a_r3_reset_value: assert property (@(posedge clk)
    rst |=> (cfg_q == 8'h77 && !wait_o));

  a_r4_enabled_waits: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !wait_o && rom_sel && cfg_q[3]) |=> wait_o);

  a_r7_no_select_idle: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !wait_o && !rom_sel && !ram_sel && cpu_waits == '0) |=> !wait_o);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (remain > CNT_W'(1)) |=> wait_o);

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (remain == CNT_W'(1)) |=> !wait_o);
endmodule

bind cswg_top cswg_chk #(
  .ADDR_W  (ADDR_W),
  .REG_W   (REG_W),
  .CPU_W   (CPU_W),
  .CNT_W   (CNT_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .cfg_q    (cfg_q),
  .cyc_start(cyc_start),
  .rom_sel  (rom_sel),
  .ram_sel  (ram_sel),
  .cpu_waits(cpu_waits),
  .wait_o   (wait_o),
  .remain   (remain)
);

// File: tb/cswg_top_tb.sv
module cswg_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] cfg_q;
  logic       cyc_start = 1'b0;
  logic       rom_sel = 1'b0;
  logic       ram_sel = 1'b0;
  logic [2:0] cpu_waits = '0;
  logic       wait_o;

  int    vectors = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R3";

  // behavioural reference
  int       m_rem = 0;
  bit [7:0] m_cfg = 8'h77;
  int       m_wins = 0;

  always #5 clk = ~clk;

  cswg_top u_dut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .cfg_q(cfg_q), .cyc_start(cyc_start), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .cpu_waits(cpu_waits), .wait_o(wait_o)
  );

  function automatic int want(bit [7:0] c, bit rs, bit as, int cpu);
    int own;
    own = 0;
    if (rs) begin
      if (c[3]) own = int'(c[2:0]) + 1;
    end else if (as) begin
      if (c[7]) own = int'(c[6:4]) + 1;
    end
    return (own > cpu) ? own : cpu;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_rem = 0;
      m_cfg = 8'h77;
    end else begin
      if (m_rem > 0) m_rem--;
      else if (cyc_start) m_rem = want(m_cfg, rom_sel, ram_sel, int'(cpu_waits));
      if (io_wr && io_addr == 8'hD8) m_cfg = io_wdata;
    end
    if (cycles >= 100000 && !done) begin
      errors++;
      $display("FAIL watchdog wait_o=%0d exp=%0d", wait_o, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (wait_o !== (m_rem > 0) || cfg_q !== m_cfg) begin
        errors++;
        $display("FAIL %s wait_o=%0d cfg_q=%02h exp wait_o=%0d cfg_q=%02h",
                 cur_req, wait_o, cfg_q, (m_rem > 0), m_cfg);
      end
    end
  end

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic cyc(input bit rs, input bit as, input int cpu, input int exp_n);
    int cnt;
    @(negedge clk);
    cyc_start = 1'b1; rom_sel = rs; ram_sel = as; cpu_waits = 3'(cpu);
    @(negedge clk);
    cyc_start = 1'b0; rom_sel = 1'b0; ram_sel = 1'b0; cpu_waits = '0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      if (wait_o) cnt++;
      @(negedge clk);
    end
    vectors++;
    if (cnt != exp_n) begin
      errors++;
      $display("FAIL %s wait length=%0d exp=%0d", cur_req, cnt, exp_n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R3";
    @(negedge clk);
    if (cfg_q !== 8'h77 || wait_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 cfg_q=%02h exp=77", cfg_q);
    end
    vectors++;
    cur_req = "R5"; cyc(1, 0, 0, 0);
    cur_req = "R5"; cyc(0, 1, 2, 2);
    // R4 / R2 ROM lane, every count
    for (int n = 0; n < 8; n++) begin
      cur_req = "R4"; wr(8'hD8, 8'h08 | 8'(n)); cyc(1, 0, 0, n + 1);
    end
    // R4 / R2 RAM lane, every count
    for (int n = 0; n < 8; n++) begin
      cur_req = "R2"; wr(8'hD8, 8'h80 | 8'(n << 4)); cyc(0, 1, 0, n + 1);
    end
    cur_req = "R6"; wr(8'hD8, 8'h8A); cyc(1, 0, 5, 5);
    cur_req = "R6"; wr(8'hD8, 8'hE8); cyc(0, 1, 2, 7);
    cur_req = "R7"; wr(8'hD8, 8'hFF); cyc(0, 0, 4, 4);
    cur_req = "R7"; cyc(0, 0, 0, 0);
    cur_req = "R8"; wr(8'hD8, 8'hF9); cyc(1, 1, 0, 2);
    cur_req = "R8"; wr(8'hD8, 8'h97); cyc(1, 1, 1, 1);
    cur_req = "R1"; wr(8'hD7, 8'h00); wr(8'h58, 8'h12);
    cur_req = "R1"; wr(8'hD8, 8'h0B); cyc(1, 0, 0, 4);
    // R10: write during the waits, then a strobe while busy
    cur_req = "R10";
    @(negedge clk);
    cyc_start = 1'b1; rom_sel = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; rom_sel = 1'b0;
    io_wr = 1'b1; io_addr = 8'hD8; io_wdata = 8'h0F;
    @(negedge clk);
    io_wr = 1'b0;
    cyc_start = 1'b1; rom_sel = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; rom_sel = 1'b0;
    repeat (12) @(negedge clk);
    cur_req = "R10"; cyc(1, 0, 0, 8);
    cur_req = "R9"; wr(8'hD8, 8'h08); cyc(1, 0, 0, 1);
    cur_req = "R3";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule